// File: doc/BRIEF.md
# NAND Page SEC-DED ECC Engine

This block sits beside the data path of a NAND flash controller. It watches the bytes of a page as they cross the data phase and folds them into a Hamming-style parity code, one independent code for each 512-byte block of the page. A page of up to four blocks (2 KB) is covered as consecutive block steps.

On a page program the finished code of each block is presented for the controller to place in the spare area behind the data. On a page read the controller supplies the code previously stored for the block. The engine forms the syndrome and classifies the block as clean, correctable (with the failing byte offset and bit index), damaged in the code itself, or uncorrectable. Data correction and flash bus timing belong to the surrounding controller.

Block accumulation is framed by the transfer addresses. A block begins only when an access starts at a 512-byte-aligned address. The page is closed by an end-of-ECC flag carried on its final byte, which is normally sent as a separate short access holding the last four bytes.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset, res_valid is 0 and res_code, res_status, res_byte, res_bit and res_idx are all zero.
- R2: A byte with in_first set starts a block only when in_addr[8:0] is zero. An unaligned in_first while no block is open is ignored, and the bytes that follow produce no result.
- R3: The code is 24 bits made of 12 parity pairs. Take each data bit's position as p = offset*8 + bit, where bit 0 is the LSB. For pair k (0..11), bit 2k+1 is the XOR of all bits whose p has bit k set, and bit 2k is the XOR of all bits whose p has bit k clear.
- R4: A result (res_valid high for one cycle) appears one cycle after the 512th byte of a block. Its res_idx is in_addr[10:9] of the aligned start, plus one for each later block in the same stream, modulo 4.
- R5: With in_read low, every result reports status 0 (clean) with res_byte and res_bit zero.
- R6: With in_read high and in_stored equal to the code of the received data, the status is 0.
- R7: With in_read high and exactly one data bit of the block flipped, the status is 1 (corrected). res_byte gives the byte offset of the flipped bit and res_bit its bit index.
- R8: With in_read high and exactly one bit of in_stored differing from the data's code, the status is 3 (code error).
- R9: With in_read high, any other nonzero syndrome gives status 2 (uncorrectable). This covers every double-bit error.
- R10: in_last on the final byte of a block closes the stream, and later bytes without an aligned in_first give no result. in_last on any other byte abandons the open block without a result.
- R11: An aligned in_first while a block is open restarts the block at offset 0, and the partial data before it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_data | input | 8 | Data byte |
| in_first | input | 1 | First byte of an access |
| in_addr | input | 11 | Byte address of this byte within the page |
| in_last | input | 1 | End-of-ECC flag on the final byte of the page |
| in_read | input | 1 | 1 = page read (check), 0 = page program (generate) |
| in_stored | input | 24 | Stored code of the current block, sampled on its last byte |
| res_valid | output | 1 | Block result strobe |
| res_idx | output | 2 | Index of the block within the page |
| res_code | output | 24 | Code computed from the received block |
| res_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 code error |
| res_byte | output | 9 | Byte offset of a corrected bit |
| res_bit | output | 3 | Bit index of a corrected bit |

## Verification
The bench sweeps single-bit data flips across every byte-address and bit-index weight, and flips every one of the 24 code bits in turn. A design with a swapped parity pair or a wrong column mask would then report a wrong position or misclassify the flip as uncorrectable. Double data flips, double code flips and a mixed data-plus-code flip must all land as uncorrectable, which exposes a classifier that accepts any pattern with nonzero odd halves. The framing cases cover an unaligned start, an end flag mid-block, bytes that trail a closed page and a restart inside an open block. A design that mistracked the offset counter would emit extra or missing results, or a code over the wrong bytes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Block result classes reported on res_status
  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2,
    ECC_CODE  = 2'd3
  } ecc_stat_e;

  // address bits that select a bit inside a byte
  localparam int BIT_AW = 3;

  // mask of byte lanes whose bit index has bit j set
  function automatic logic [7:0] lane_mask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/nand_ecc_parity.sv
module nand_ecc_parity
  import nand_ecc_pkg::*;
#(
  parameter int BLK_AW = 9,
  localparam int PAIRS = BLK_AW + BIT_AW,
  localparam int CODE_W = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BLK_AW-1:0] offset,
  input  logic [7:0]        data,
  output logic [CODE_W-1:0] code_next
);

  logic [CODE_W-1:0] acc;
  logic [CODE_W-1:0] contrib;
  logic [CODE_W-1:0] base;
  logic              byte_par;

  assign byte_par = ^data;

  generate
    // column pairs: parity over bit lanes of every byte
    for (genvar j = 0; j < BIT_AW; j++) begin : g_col
      localparam logic [7:0] M = lane_mask(j);
      assign contrib[2*j+1] = ^(data & M);
      assign contrib[2*j]   = ^(data & ~M);
    end
    // line pairs: whole-byte parity steered by the byte offset
    for (genvar i = 0; i < BLK_AW; i++) begin : g_line
      assign contrib[2*(BIT_AW+i)+1] = byte_par & offset[i];
      assign contrib[2*(BIT_AW+i)]   = byte_par & ~offset[i];
    end
  endgenerate

  // offset zero always opens a fresh block
  assign base      = (offset == '0) ? '0 : acc;
  assign code_next = base ^ contrib;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= code_next;
  end

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int PAIRS = 12,
  localparam int CODE_W = 2 * PAIRS
) (
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] computed,
  output ecc_stat_e         status,
  output logic [PAIRS-1:0]  err_pos
);

  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pair_one;

  assign syn = stored ^ computed;

  generate
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign pair_one[k] = syn[2*k] ^ syn[2*k+1];
      assign err_pos[k]  = syn[2*k+1];
    end
  endgenerate

  always_comb begin
    if (syn == '0)                                   status = ECC_CLEAN;
    else if (&pair_one)                              status = ECC_FIXED;
    else if ((syn & (syn - CODE_W'(1))) == '0)       status = ECC_CODE;
    else                                             status = ECC_FATAL;
  end

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int PAGE_BLKS = 4,
  localparam int BLK_AW  = $clog2(BLK_BYTES),
  localparam int IDX_W   = (PAGE_BLKS > 1) ? $clog2(PAGE_BLKS) : 1,
  localparam int PAGE_AW = BLK_AW + IDX_W,
  localparam int PAIRS   = BLK_AW + BIT_AW,
  localparam int CODE_W  = 2 * PAIRS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_first,
  input  logic [PAGE_AW-1:0] in_addr,
  input  logic               in_last,
  input  logic               in_read,
  input  logic [CODE_W-1:0]  in_stored,
  output logic               res_valid,
  output logic [IDX_W-1:0]   res_idx,
  output logic [CODE_W-1:0]  res_code,
  output logic [1:0]         res_status,
  output logic [BLK_AW-1:0]  res_byte,
  output logic [BIT_AW-1:0]  res_bit
);

  localparam logic [BLK_AW-1:0] LAST_OFF = BLK_AW'(BLK_BYTES - 1);

  logic              armed;
  logic [BLK_AW-1:0] cnt;
  logic [IDX_W-1:0]  idx;

  logic              start_ok;
  logic              accept;
  logic              blk_end;
  logic [BLK_AW-1:0] offset;
  logic [IDX_W-1:0]  cur_idx;
  logic [CODE_W-1:0] code_next;
  ecc_stat_e         cls_status;
  logic [PAIRS-1:0]  cls_pos;

  // framing: only an aligned access opens a block
  assign start_ok = in_valid && in_first && (in_addr[BLK_AW-1:0] == '0);
  assign accept   = in_valid && (armed || start_ok);
  assign offset   = start_ok ? '0 : cnt;
  assign cur_idx  = start_ok ? in_addr[PAGE_AW-1:BLK_AW] : idx;
  assign blk_end  = accept && (offset == LAST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
    end else if (accept) begin
      cnt   <= offset + 1'b1;
      idx   <= blk_end ? cur_idx + 1'b1 : cur_idx;
      armed <= !in_last;
    end
  end

  nand_ecc_parity #(.BLK_AW(BLK_AW)) u_parity (
    .clk       (clk),
    .rst       (rst),
    .en        (accept),
    .offset    (offset),
    .data      (in_data),
    .code_next (code_next)
  );

  nand_ecc_classify #(.PAIRS(PAIRS)) u_classify (
    .stored   (in_stored),
    .computed (code_next),
    .status   (cls_status),
    .err_pos  (cls_pos)
  );

  // result register, one cycle after the closing byte of a block
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_idx    <= '0;
      res_code   <= '0;
      res_status <= ECC_CLEAN;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= blk_end;
      if (blk_end) begin
        res_idx  <= cur_idx;
        res_code <= code_next;
        if (in_read && cls_status == ECC_FIXED) begin
          res_status <= ECC_FIXED;
          res_byte   <= cls_pos[PAIRS-1:BIT_AW];
          res_bit    <= cls_pos[BIT_AW-1:0];
        end else begin
          res_status <= in_read ? cls_status : ECC_CLEAN;
          res_byte   <= '0;
          res_bit    <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk #(
  parameter int BYTE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_read,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic [BYTE_W-1:0] res_byte,
  input logic [2:0]        res_bit
);

  // R4: a result always follows a byte taken on the previous cycle
  a_r4_follows_byte: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));

  // R4: blocks are many bytes long, so strobes never touch
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R5: program streams report clean blocks only
  a_r5_write_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(in_read)) |-> (res_status == 2'd0));

  // R7: a bit position is reported only with a correction
  a_r7_pos_only_fixed: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status != 2'd1) |-> (res_byte == '0 && res_bit == '0));

endmodule

bind nand_ecc_engine nand_ecc_engine_chk #(.BYTE_W(BLK_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_read    (in_read),
  .res_valid  (res_valid),
  .res_status (res_status),
  .res_byte   (res_byte),
  .res_bit    (res_bit)
);

// File: tb/nand_ecc_engine_test.sv
`timescale 1ns/1ps
module nand_ecc_engine_test;
  localparam int BLK = 512;
  localparam int NB  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_first = 1'b0;
  logic [10:0] in_addr = '0;
  logic        in_last = 1'b0;
  logic        in_read = 1'b0;
  logic [23:0] in_stored = '0;
  logic        res_valid;
  logic [1:0]  res_idx;
  logic [23:0] res_code;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;

  always #4 clk = ~clk;

  nand_ecc_engine uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_addr(in_addr), .in_last(in_last),
    .in_read(in_read), .in_stored(in_stored), .res_valid(res_valid),
    .res_idx(res_idx), .res_code(res_code), .res_status(res_status),
    .res_byte(res_byte), .res_bit(res_bit)
  );

  int errors = 0;
  int checks = 0;

  logic [23:0] q_code[$];
  logic [1:0]  q_idx[$];
  logic [1:0]  q_stat[$];
  logic [8:0]  q_byte[$];
  logic [2:0]  q_bit[$];

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      q_code.push_back(res_code);
      q_idx.push_back(res_idx);
      q_stat.push_back(res_status);
      q_byte.push_back(res_byte);
      q_bit.push_back(res_bit);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int b, input int i);
    int v;
    v = i * 37 + seed * 101 + b * 59 + (i >> 4) * 11;
    return 8'(v ^ (seed * 3));
  endfunction

  // code by direct definition over bit positions, with optional flips
  function automatic logic [23:0] ref_code(input int seed, input int b,
                                           input int f1, input int f2);
    logic [23:0] c;
    logic [7:0]  d;
    logic        bv;
    c = '0;
    for (int pos = 0; pos < BLK * 8; pos++) begin
      d  = gen(seed, b, pos >> 3);
      bv = d[pos & 7] ^ (pos == f1) ^ (pos == f2);
      for (int k = 0; k < 12; k++) begin
        if (((pos >> k) & 1) == 1) c[2*k+1] ^= bv;
        else                       c[2*k]   ^= bv;
      end
    end
    return c;
  endfunction

  int          f1[NB];
  int          f2[NB];
  logic [23:0] smask[NB];
  int          es[NB];

  task automatic put(input logic [7:0] d, input bit first, input int addr,
                     input bit last, input bit rd, input logic [23:0] st);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = first; in_addr = 11'(addr);
    in_last = last; in_read = rd; in_stored = st;
  endtask

  task automatic quiet(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic clearq();
    q_code.delete(); q_idx.delete(); q_stat.delete();
    q_byte.delete(); q_bit.delete();
  endtask

  task automatic preset();
    for (int b = 0; b < NB; b++) begin
      f1[b] = -1; f2[b] = -1; smask[b] = '0; es[b] = 0;
    end
  endtask

  // full page; the final four bytes go as a separate unaligned access
  task automatic run_page(input int seed, input bit rd, input string req);
    logic [23:0] clean[NB];
    logic [7:0]  d;
    int          n;
    for (int b = 0; b < NB; b++) clean[b] = ref_code(seed, b, -1, -1);
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < BLK; i++) begin
        d = gen(seed, b, i);
        for (int j = 0; j < 8; j++)
          d[j] = d[j] ^ ((i*8+j) == f1[b]) ^ ((i*8+j) == f2[b]);
        put(d, (b == 0 && i == 0) || (b == NB-1 && i == BLK-4), b*BLK + i,
            (b == NB-1 && i == BLK-1), rd, clean[b] ^ smask[b]);
      end
    end
    quiet(3);
    n = q_code.size();
    chk(n == NB, "R4", "result count", n, NB);
    for (int b = 0; b < NB && b < n; b++) begin
      chk(q_idx[b] == 2'(b), "R4", "block index", q_idx[b], b);
      chk(q_stat[b] == 2'(es[b]), req, "status", q_stat[b], es[b]);
      if (!rd || es[b] == 0)
        chk(q_code[b] == clean[b], "R3", "code", q_code[b], clean[b]);
      if (es[b] == 1) begin
        chk(q_byte[b] == 9'(f1[b] >> 3), "R7", "byte offset", q_byte[b], f1[b] >> 3);
        chk(q_bit[b] == 3'(f1[b] & 7), "R7", "bit index", q_bit[b], f1[b] & 7);
      end
    end
    clearq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(res_valid == 1'b0, "R1", "valid", res_valid, 0);
    chk(res_code == '0 && res_status == '0, "R1", "code/status",
        {res_code, res_status}, 0);
    chk(res_byte == '0 && res_bit == '0 && res_idx == '0, "R1", "position",
        {res_idx, res_byte, res_bit}, 0);

    // R5 program page
    preset(); run_page(1, 1'b0, "R5");
    // R6 clean read
    preset(); run_page(2, 1'b1, "R6");

    // R7 single data flips over every address weight and more
    for (int p = 0; p < 6; p++) begin
      preset();
      for (int b = 0; b < NB; b++) begin
        int k = p * NB + b;
        f1[b] = (k < 12) ? (1 << k) : ((k * 331 + 5) % 4096);
        es[b] = 1;
      end
      run_page(10 + p, 1'b1, "R7");
    end

    // R8 each stored code bit flipped alone
    for (int p = 0; p < 6; p++) begin
      preset();
      for (int b = 0; b < NB; b++) begin
        smask[b] = 24'(1) << (p * NB + b);
        es[b] = 3;
      end
      run_page(20 + p, 1'b1, "R8");
    end

    // R9 double data flips
    preset();
    f1[0] = 0;   f2[0] = 1;
    f1[1] = 8;   f2[1] = 4095;
    f1[2] = 100; f2[2] = 2000;
    f1[3] = 7;   f2[3] = 15;
    for (int b = 0; b < NB; b++) es[b] = 2;
    run_page(30, 1'b1, "R9");
    // R9 double code flips and mixed data plus code flips
    preset();
    smask[0] = 24'h3; smask[1] = 24'h300;
    f1[2] = 77;  smask[2] = 24'h10;
    f1[3] = 3000; smask[3] = 24'h800000;
    for (int b = 0; b < NB; b++) es[b] = 2;
    run_page(31, 1'b1, "R9");

    // R2 unaligned start is ignored
    for (int i = 0; i < 600; i++) put(gen(5, 0, i), i == 0, 4 + i, 1'b0, 1'b0, '0);
    quiet(3);
    chk(q_code.size() == 0, "R2", "results after unaligned start", q_code.size(), 0);
    clearq();
    // R2/R4 aligned start in the second block slot
    for (int i = 0; i < BLK; i++)
      put(gen(7, 1, i), i == 0, BLK + i, i == BLK-1, 1'b0, '0);
    quiet(3);
    chk(q_code.size() == 1, "R2", "results after aligned start", q_code.size(), 1);
    if (q_code.size() == 1) begin
      chk(q_idx[0] == 2'd1, "R4", "index from start address", q_idx[0], 1);
      chk(q_code[0] == ref_code(7, 1, -1, -1), "R3", "code", q_code[0],
          ref_code(7, 1, -1, -1));
    end
    clearq();

    // R10 end flag mid-block abandons it; trailing bytes ignored
    for (int i = 0; i < 100; i++) put(gen(8, 0, i), i == 0, i, i == 99, 1'b0, '0);
    for (int i = 100; i < 700; i++) put(gen(8, 0, i), 1'b0, i, 1'b0, 1'b0, '0);
    quiet(3);
    chk(q_code.size() == 0, "R10", "results after mid-block end", q_code.size(), 0);
    clearq();
    // R10 end flag on a boundary closes the stream
    for (int i = 0; i < BLK + 520; i++)
      put(gen(8, 0, i), i == 0, i, i == BLK-1, 1'b0, '0);
    quiet(3);
    chk(q_code.size() == 1, "R10", "results after closed page", q_code.size(), 1);
    clearq();

    // R11 aligned restart inside an open block
    for (int i = 0; i < 200; i++) put(gen(9, 0, i + 300), i == 0, i, 1'b0, 1'b0, '0);
    for (int i = 0; i < BLK; i++) put(gen(9, 0, i), i == 0, i, i == BLK-1, 1'b0, '0);
    quiet(3);
    chk(q_code.size() == 1, "R11", "results after restart", q_code.size(), 1);
    if (q_code.size() == 1)
      chk(q_code[0] == ref_code(9, 0, -1, -1), "R11", "code after restart",
          q_code[0], ref_code(9, 0, -1, -1));
    clearq();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule